// File: doc/BRIEF.md
# Preloadable Up-Counting Timer with Prescaler

This block is a timer that counts up from a value written by software and raises a one-cycle overflow request each time it wraps past its all-ones value. On each wrap it takes its start value again from a reload buffer, so it runs as a periodic interrupt source. The period is chosen by writing the complement of the wanted tick count: for an N-bit counter, software writes 2^N minus the count.

The tick comes from the system clock through a clock-enable input and a power-of-two prescaler. A control register holds the prescaler tap, a two-bit operating mode and a start bit. The counter runs only while the start bit is set and the mode field selects the internal-clock timer mode. The counter width is a parameter. The 16-bit build takes its preload as a low byte and then a high byte. The 8-bit build takes it in a single byte.

Software reaches all of this through a byte-wide register port. Writes are synchronous. Reads are combinational and return the live count or the control register.

Top module: `ptimer`

## Requirements
- R1: Reset is synchronous and active high. After reset the control register, the count and the reload buffer read as zero, and `ovf_irq` is low.
- R2: With preload P and prescaler divide D, `ovf_irq` goes high for one cycle (2^N − P)·D enabled clocks after the start write. The only exception is a period of one tick at divide 1.
- R3: On a wrap the counter takes the reload value in the same cycle. Successive overflow pulses are therefore exactly (2^N − P)·D cycles apart, and with P = 2^N − 1 at divide 1 the request stays high on every cycle.
- R4: Control bits [2:0] select the prescaler divide as 2^value (0 = every enabled clock, 3 = /8, 4 = /16, 5 = /32). The prescaler restarts from zero whenever the timer is stopped.
- R5: Control bit 4 is the start bit. Counting happens only while it is 1 and control bits [7:6] equal 2'b10 (control value 0x80 = timer mode). Otherwise the count holds.
- R6: While the timer runs, a control write updates only the start bit. The mode and prescaler fields keep their values, and bits 5 and 3 always read 0.
- R7: In the 16-bit build, address 0 writes a low-byte staging register. A write to address 1 commits {high, staged low} to the reload buffer. A low-byte write on its own changes neither the count nor the reload.
- R8: A commit while the timer is stopped also loads the counter at once. A commit while it runs changes only the reload buffer.
- R9: Reads are combinational. Address 0 returns count bits [7:0], address 1 returns count bits [15:8] (zero in the 8-bit build), address 2 returns the control register and address 3 returns zero.
- R10: When a commit falls in the same cycle as a wrap, the wrap reloads the previous buffer value. The new value governs the period from the next wrap on.
- R11: While `tick_en` is low, both the prescaler and the count hold.
- R12: In the 8-bit build, a write to address 0 commits the preload directly, and a write to address 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Clock enable feeding the prescaler |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 low, 1 high, 2 control) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Combinational register read data |
| ovf_irq | output | 1 | One-cycle overflow request |

## Verification
Two functions can fall on the same clock edge: the overflow reload and a high-byte commit made while the timer runs. The bench starts a 16-tick period and writes a new staged low byte. It then places the high-byte write exactly on the 16th edge after the start. The count read just after that edge must show the old reload value. The next two pulse gaps must be 16 cycles and then 8 cycles, which shows the new preload only took effect from the following wrap.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

    // Prescaler tap select width; prescaler counter width follows from it
    localparam int PS_SEL_W = 3;
    localparam int PS_W     = (1 << PS_SEL_W) - 1;

    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_EVT = 2'b01,
        MODE_TMR = 2'b10,
        MODE_RSV = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        tmr_mode_e             mode;    // [7:6]
        logic                  rsv5;    // [5]
        logic                  start;   // [4]
        logic                  rsv3;    // [3]
        logic [PS_SEL_W-1:0]   ps_sel;  // [2:0]
    } tmr_ctrl_t;

    typedef enum logic [1:0] {
        ADDR_LO   = 2'd0,
        ADDR_HI   = 2'd1,
        ADDR_CTRL = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    // Low "sel" bits set: tick fires when these prescaler bits are all ones
    function automatic logic [PS_W-1:0] tap_mask(input logic [PS_SEL_W-1:0] sel);
        return PS_W'((32'd1 << sel) - 32'd1);
    endfunction

endpackage

// File: rtl/ptimer_prescaler.sv
module ptimer_prescaler
    import ptimer_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                tick_en,
    input  logic [PS_SEL_W-1:0] sel,
    output logic                tick
);

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] mask;

    assign mask = tap_mask(sel);
    assign tick = run && tick_en && ((ps_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ps_q <= '0;
        end else if (tick_en) begin
            ps_q <= ps_q + 1'b1;
        end
    end

    // R11
    ps_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !tick_en) |=> (ps_q == $past(ps_q)));

endmodule

// File: rtl/ptimer_counter.sv
module ptimer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load_now,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic wrap;
    logic armed;

    assign wrap = tick && (cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= wrap;
            if (load_now) begin
                cnt_q <= load_val;
            end else if (wrap) begin
                cnt_q <= reload;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R3 R10
    reload_on_wrap_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        ovf_q |-> (cnt_q == $past(reload)));

    // R2
    ovf_needs_tick_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        ovf_q |-> $past(tick));

    // R11
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (!$past(tick) && !$past(load_now)) |-> $stable(cnt_q));

endmodule

// File: rtl/ptimer_regs.sv
module ptimer_regs
    import ptimer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    input  logic [CNT_W-1:0] cnt,
    output logic [7:0]       rdata,
    output tmr_ctrl_t        ctrl,
    output logic             running,
    output logic [CNT_W-1:0] reload_q,
    output logic             commit,
    output logic [CNT_W-1:0] commit_val
);

    localparam bit WIDE = (CNT_W > 8);

    logic [7:0] hi_byte;
    logic       ctrl_wr;

    assign ctrl_wr = we && (addr == ADDR_CTRL);
    assign running = ctrl.start && (ctrl.mode == MODE_TMR);

    generate
        if (WIDE) begin : g_wide
            logic [7:0] lo_stage;

            assign commit     = we && (addr == ADDR_HI);
            assign commit_val = {wdata[CNT_W-9:0], lo_stage};
            assign hi_byte    = 8'(cnt[CNT_W-1:8]);

            always_ff @(posedge clk) begin
                if (rst) begin
                    lo_stage <= '0;
                end else if (we && (addr == ADDR_LO)) begin
                    lo_stage <= wdata;
                end
            end

            // R7
            lo_only_chk: assert property (@(posedge clk) disable iff (rst)
                (we && (addr == ADDR_LO)) |=> (reload_q == $past(reload_q)));
        end else begin : g_narrow
            assign commit     = we && (addr == ADDR_LO);
            assign commit_val = wdata[CNT_W-1:0];
            assign hi_byte    = 8'h00;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
        end else if (commit) begin
            reload_q <= commit_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.start <= wdata[4];
            if (!running) begin
                ctrl.mode   <= tmr_mode_e'(wdata[7:6]);
                ctrl.ps_sel <= wdata[PS_SEL_W-1:0];
            end
        end
    end

    always_comb begin
        case (reg_addr_e'(addr))
            ADDR_LO:   rdata = cnt[7:0];
            ADDR_HI:   rdata = hi_byte;
            ADDR_CTRL: rdata = ctrl;
            default:   rdata = 8'h00;
        endcase
    end

    // R6
    mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (running && ctrl_wr) |=> ((ctrl.mode == $past(ctrl.mode)) &&
                                  (ctrl.ps_sel == $past(ctrl.ps_sel))));

endmodule

// File: rtl/ptimer.sv
module ptimer
    import ptimer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       bus_we,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       ovf_irq
);

    tmr_ctrl_t        ctrl;
    logic             running;
    logic             tick;
    logic             commit;
    logic [CNT_W-1:0] commit_val;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;

    ptimer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (bus_we),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .cnt        (cnt_q),
        .rdata      (bus_rdata),
        .ctrl       (ctrl),
        .running    (running),
        .reload_q   (reload_q),
        .commit     (commit),
        .commit_val (commit_val)
    );

    ptimer_prescaler u_ps (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .tick_en (tick_en),
        .sel     (ctrl.ps_sel),
        .tick    (tick)
    );

    ptimer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load_now (commit && !running),
        .load_val (commit_val),
        .reload   (reload_q),
        .cnt_q    (cnt_q),
        .ovf_q    (ovf_irq)
    );

endmodule

// File: tb/ptimer_bench.sv
`timescale 1ns/1ps
module ptimer_bench;

    typedef struct packed {
        logic [15:0] pre;
        logic [2:0]  sel;
        logic [31:0] period;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{16'hFFF6, 3'd0, 32'd10},
        '{16'hFFFB, 3'd3, 32'd40},
        '{16'hFFFE, 3'd4, 32'd32},
        '{16'hFFFD, 3'd5, 32'd96},
        '{16'hFF00, 3'd0, 32'd256}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] rdata16, rdata8;
    logic       ovf16, ovf8;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ptimer u_ptimer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata16), .ovf_irq(ovf16)
    );

    ptimer #(.CNT_W(8)) u_ptimer_w8 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata8), .ovf_irq(ovf8)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd16(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = rdata16;
    endtask

    task automatic rd8(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = rdata8;
    endtask

    task automatic wait_ovf(output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!ovf16 && n < 100000);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd16(2'd2, d); chk("R1 ctrl", d, 8'h00);
        rd16(2'd0, d); chk("R1 count lo", d, 8'h00);
        rd16(2'd1, d); chk("R1 count hi", d, 8'h00);
        chk("R1 ovf", ovf16, 1'b0);
        chk("R1 ovf w8", ovf8, 1'b0);
        // R9 unused address
        rd16(2'd3, d); chk("R9 addr3", d, 8'h00);

        tick_en = 1'b1;

        // Table walk: R2 first period, R3/R4 steady period, R12 8-bit build
        for (int i = 0; i < NVEC; i++) begin
            wr(2'd2, 8'h00);
            wr(2'd2, 8'h80 | 8'(VECS[i].sel));
            wr(2'd0, VECS[i].pre[7:0]);
            wr(2'd1, VECS[i].pre[15:8]);
            wr(2'd2, 8'h90 | 8'(VECS[i].sel));
            wait_ovf(n);
            chk("R2 first period", n, VECS[i].period);
            chk("R12 w8 overflow together", ovf8, 1'b1);
            wait_ovf(n);
            chk("R3 R4 steady period", n, VECS[i].period);
        end

        wr(2'd2, 8'h00);
        rd16(2'd2, d); chk("R6 stop keeps mode", d, 8'h80);

        // R8 stopped commit loads counter, R9 read map
        wr(2'd0, 8'h56);
        wr(2'd1, 8'h12);
        rd16(2'd0, d); chk("R8 R9 load lo", d, 8'h56);
        rd16(2'd1, d); chk("R8 R9 load hi", d, 8'h12);
        // R7 low byte alone has no effect
        wr(2'd0, 8'h34);
        rd16(2'd0, d); chk("R7 lo-only ignored", d, 8'h56);
        rd8(2'd0, d);  chk("R12 w8 direct commit", d, 8'h34);
        rd8(2'd1, d);  chk("R9 w8 hi reads zero", d, 8'h00);
        wr(2'd1, 8'hAB);
        rd16(2'd1, d); chk("R7 commit hi", d, 8'hAB);
        rd16(2'd0, d); chk("R7 commit lo", d, 8'h34);
        rd8(2'd0, d);  chk("R12 w8 hi write ignored", d, 8'h34);

        // R5 counting from 0xAB34 at divide 1
        wr(2'd2, 8'h90);
        repeat (5) @(negedge clk);
        rd16(2'd0, d); chk("R5 counts", d, 8'h39);
        // R8 running commit leaves count alone
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        rd16(2'd0, d); chk("R8 running commit", d, 8'h3B);
        // R11 tick_en low freezes
        tick_en = 1'b0;
        repeat (4) @(negedge clk);
        rd16(2'd0, d); chk("R11 hold", d, 8'h3B);
        tick_en = 1'b1;

        // R6 mode/prescaler locked while running
        wr(2'd2, 8'h13);
        rd16(2'd2, d); chk("R6 locked fields", d, 8'h90);
        wr(2'd2, 8'h03);
        rd16(2'd2, d); chk("R6 start cleared only", d, 8'h80);
        rd16(2'd0, d);
        repeat (3) @(negedge clk);
        begin
            logic [7:0] d2;
            rd16(2'd0, d2); chk("R5 stopped holds", d2, d);
        end

        // R5 non-timer mode does not count
        wr(2'd2, 8'h00);
        wr(2'd2, 8'h10);
        rd16(2'd2, d); chk("R5 ctrl mode off", d, 8'h10);
        rd16(2'd0, d);
        repeat (4) @(negedge clk);
        begin
            logic [7:0] d2;
            rd16(2'd0, d2); chk("R5 mode off holds", d2, d);
        end
        wr(2'd2, 8'h00);

        // R10 commit on the wrap edge
        wr(2'd2, 8'h80);
        wr(2'd0, 8'hF0);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h90);
        wr(2'd0, 8'hF8);
        repeat (14) @(negedge clk);
        wr(2'd1, 8'hFF);
        chk("R2 wrap at edge 16", ovf16, 1'b1);
        rd16(2'd0, d); chk("R10 old reload used", d, 8'hF0);
        wait_ovf(n); chk("R10 old period", n, 16);
        wait_ovf(n); chk("R10 new period", n, 8);

        // R3 one-tick period keeps request high
        wr(2'd2, 8'h00);
        wr(2'd2, 8'h80);
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h90);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R3 period one", ovf16, 1'b1);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule